// File: doc/BRIEF.md
# Byte Permute and Mirror Execute Unit

This execute-stage unit performs a byte-permute operation for a 32-bit processor. A 32-bit source operand is split into four byte lanes numbered little-endian. Each of the four result lanes independently picks any source lane through a 2-bit selector packed into a 9-bit immediate. A single flag in that immediate can also reverse the bit order inside every picked byte. Selectors may repeat, so one source byte can fill several lanes while other source bytes are dropped.

The operation is accepted under one secondary opcode of a register-plus-constant instruction group, and only while a feature-revision enable is high. If that enable is low, or if the secondary opcode is not the permute code, the unit raises an illegal-opcode trap instead of a result. The destination register index travels with the operation so that writeback knows where the result goes. Outputs are registered once, so a result or trap appears exactly one cycle after the input.

A small state machine holds the outcome of the previous cycle. `ST_IDLE` means no output is being presented. `ST_RESULT` means the result is valid. `ST_TRAP` means the trap is raised. From every state, the next state is chosen from the current input:
- a valid input with the permute opcode and the enable high goes to `ST_RESULT` (transition "accept");
- any other valid input goes to `ST_TRAP` (transition "reject");
- no valid input goes to `ST_IDLE` (transition "drain");
- synchronous reset forces `ST_IDLE`.

Top module: `byte_permute_unit`

## Requirements
- R1: Source and result bytes are numbered little-endian: lane k is bits 8k+7:8k. Result lane k takes the source lane given by immediate bits 2k+1:2k. So bits 1:0 feed lane 0 and bits 7:6 feed lane 3.
- R2: When immediate bit 8 is 1, each of the four picked bytes has its bits reversed after selection (bit 0 swaps with bit 7, bit 1 with bit 6, and so on). When bit 8 is 0, the bytes pass unchanged.
- R3: Selectors may repeat. For example, immediate 0x000 fills all four lanes with source byte 0, and 0x0FF fills them with source byte 3.
- R4: A valid input with secondary opcode 0x07 and the feature enable high gives out_valid=1, out_trap=0 and the permuted out_data on the next cycle.
- R5: A valid input with opcode 0x07 and the feature enable low gives out_trap=1 and out_valid=0 on the next cycle, and leaves out_data unchanged.
- R6: A valid input with any secondary opcode other than 0x07 gives out_trap=1 and out_valid=0 on the next cycle, whatever the feature enable is. It leaves out_data unchanged.
- R7: Outputs appear exactly one cycle after the input. out_valid and out_trap are never both 1. A cycle without in_valid gives both low on the next cycle.
- R8: Whenever out_valid or out_trap is 1, out_dst equals the in_dst given with the input one cycle earlier.
- R9: A synchronous active-high reset gives out_valid=0, out_trap=0 and out_data=0 on the cycle after it is sampled. Reset takes priority over a valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_feat_en | input | 1 | Feature-revision enable for the permute operation |
| in_subop | input | 7 | Secondary opcode within the group |
| in_imm | input | 9 | Constant field: four 2-bit selectors plus the mirror flag at bit 8 |
| in_src | input | 32 | Source register value |
| in_dst | input | 4 | Destination register index |
| out_valid | output | 1 | Result valid |
| out_trap | output | 1 | Illegal-opcode trap |
| out_data | output | 32 | Permuted result |
| out_dst | output | 4 | Destination index passed through |

## Verification
The identity selector 0xE4 shows that the lane numbering is not swapped. Reversed orders such as 0x1B show that every selector field reaches its own lane. Broadcast selectors (0x00, 0x55, 0xAA, 0xFF) show that selection is a true many-to-one pick rather than a fixed swap network. The same patterns with bit 8 set separate byte-wise mirroring from a whole-word reversal. Random operands and immediates, run back-to-back and with idle gaps, are compared against a behavioural model every cycle. Disabled-feature and foreign-opcode inputs, including a mid-run reset, tell the trap path apart from the result path and check that a rejected input leaves the held result untouched.

// File: rtl/bsx_pkg.sv
package bsx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESULT,
        ST_TRAP
    } stage_e;

    localparam int          SUBOP_BITS    = 7;
    localparam logic [6:0]  SUBOP_PERMUTE = 7'h07;
endpackage

// File: rtl/bsx_lane_pick.sv
module bsx_lane_pick #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4,
    parameter int SEL_W  = $clog2(LANES)
) (
    input  logic [LANES*LANE_W-1:0] src,
    input  logic [SEL_W-1:0]        sel,
    output logic [LANE_W-1:0]       lane_out
);
    always_comb begin
        lane_out = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel == SEL_W'(i)) lane_out = src[i*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/bsx_bit_mirror.sv
module bsx_bit_mirror #(
    parameter int LANE_W = 8
) (
    input  logic              en,
    input  logic [LANE_W-1:0] d,
    output logic [LANE_W-1:0] q
);
    logic [LANE_W-1:0] flipped;

    for (genvar b = 0; b < LANE_W; b++) begin : g_bit
        assign flipped[b] = d[LANE_W-1-b];
    end

    assign q = en ? flipped : d;
endmodule

// File: rtl/bsx_decode.sv
module bsx_decode #(
    parameter int                 SUBOP_W = 7,
    parameter logic [SUBOP_W-1:0] CODE    = 7'h07
) (
    input  logic               valid,
    input  logic               feat_en,
    input  logic [SUBOP_W-1:0] subop,
    output logic               accept,
    output logic               reject
);
    logic is_code;
    assign is_code = (subop == CODE);
    assign accept  = valid && is_code && feat_en;
    assign reject  = valid && !(is_code && feat_en);
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit
    import bsx_pkg::*;
#(
    parameter int LANE_W  = 8,
    parameter int LANES   = 4,
    parameter int IDX_W   = 4,
    parameter int SUBOP_W = SUBOP_BITS,
    localparam int DATA_W = LANES * LANE_W,
    localparam int SEL_W  = $clog2(LANES),
    localparam int IMM_W  = LANES * SEL_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic               in_feat_en,
    input  logic [SUBOP_W-1:0] in_subop,
    input  logic [IMM_W-1:0]   in_imm,
    input  logic [DATA_W-1:0]  in_src,
    input  logic [IDX_W-1:0]   in_dst,
    output logic               out_valid,
    output logic               out_trap,
    output logic [DATA_W-1:0]  out_data,
    output logic [IDX_W-1:0]   out_dst
);
    localparam logic [SUBOP_W-1:0] PERMUTE_CODE = SUBOP_W'(SUBOP_PERMUTE);

    logic              do_accept;
    logic              do_reject;
    logic              mirror_on;
    logic [DATA_W-1:0] permuted;
    stage_e            state_q;
    stage_e            state_d;

    bsx_decode #(.SUBOP_W(SUBOP_W), .CODE(PERMUTE_CODE)) u_dec (
        .valid   (in_valid),
        .feat_en (in_feat_en),
        .subop   (in_subop),
        .accept  (do_accept),
        .reject  (do_reject)
    );

    assign mirror_on = in_imm[IMM_W-1];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] picked;

        bsx_lane_pick #(.LANE_W(LANE_W), .LANES(LANES), .SEL_W(SEL_W)) u_pick (
            .src      (in_src),
            .sel      (in_imm[k*SEL_W +: SEL_W]),
            .lane_out (picked)
        );

        bsx_bit_mirror #(.LANE_W(LANE_W)) u_mirror (
            .en (mirror_on),
            .d  (picked),
            .q  (permuted[k*LANE_W +: LANE_W])
        );
    end

    // next-state: accept / reject / drain, identical from every state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_TRAP: begin
                if (do_accept)      state_d = ST_RESULT;
                else if (do_reject) state_d = ST_TRAP;
                else                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            out_data <= '0;
            out_dst  <= '0;
        end else begin
            if (do_accept) out_data <= permuted;
            if (in_valid)  out_dst  <= in_dst;
        end
    end

    assign out_valid = (state_q == ST_RESULT);
    assign out_trap  = (state_q == ST_TRAP);
endmodule

// File: rtl/byte_permute_unit_chk.sv
module byte_permute_unit_chk #(
    parameter int SUBOP_W = 7,
    parameter int IMM_W   = 9,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_feat_en,
    input logic [SUBOP_W-1:0] in_subop,
    input logic [IMM_W-1:0]   in_imm,
    input logic [DATA_W-1:0]  in_src,
    input logic [IDX_W-1:0]   in_dst,
    input logic               out_valid,
    input logic               out_trap,
    input logic [DATA_W-1:0]  out_data,
    input logic [IDX_W-1:0]   out_dst
);
    logic is_code;
    assign is_code = (in_subop == SUBOP_W'(7));

    // R7
    exclusive_out_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_trap));

    // R4
    accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_code && in_feat_en) |=> (out_valid && !out_trap));

    // R5
    disabled_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_code && !in_feat_en) |=> (out_trap && !out_valid && $stable(out_data)));

    // R6
    foreign_trap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !is_code) |=> (out_trap && !out_valid && $stable(out_data)));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_trap));

    // R8
    dst_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_dst == $past(in_dst)));

    // R1
    identity_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && is_code && in_feat_en && in_imm == IMM_W'(9'h0E4)) |=> (out_data == $past(in_src)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_trap && out_data == '0));
endmodule

bind byte_permute_unit byte_permute_unit_chk #(
    .SUBOP_W (SUBOP_W),
    .IMM_W   (IMM_W),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W)
) u_chk (.*);

// File: tb/byte_permute_unit_test.sv
module byte_permute_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_feat_en;
    logic [6:0]  in_subop;
    logic [8:0]  in_imm;
    logic [31:0] in_src;
    logic [3:0]  in_dst;
    logic        out_valid;
    logic        out_trap;
    logic [31:0] out_data;
    logic [3:0]  out_dst;

    byte_permute_unit uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;
    bit armed      = 1'b0;

    logic        e_valid, e_trap;
    logic [31:0] e_data;
    logic [3:0]  e_dst;
    string       t_ctl, t_data;

    function automatic logic [31:0] model(logic [31:0] s, logic [8:0] imm);
        logic [31:0] r = '0;
        for (int lane = 0; lane < 4; lane++) begin
            int pick = (imm >> (2*lane)) & 3;
            logic [7:0] b = s[8*pick +: 8];
            logic [7:0] m = b;
            if (imm[8]) for (int j = 0; j < 8; j++) m[j] = b[7-j];
            r[8*lane +: 8] = m;
        end
        return r;
    endfunction

    task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit r, bit v, bit fe, logic [6:0] op, logic [8:0] imm,
                        logic [31:0] s, logic [3:0] d, string tag);
        @(negedge clk);
        if (armed) begin
            cmp(t_ctl, "out_valid", {31'b0, out_valid}, {31'b0, e_valid});
            cmp(t_ctl, "out_trap",  {31'b0, out_trap},  {31'b0, e_trap});
            cmp(t_data, "out_data", out_data, e_data);
            if (e_valid || e_trap) cmp("R8", "out_dst", {28'b0, out_dst}, {28'b0, e_dst});
        end
        rst = r; in_valid = v; in_feat_en = fe; in_subop = op;
        in_imm = imm; in_src = s; in_dst = d;
        if (r) begin
            armed = 1'b1;
            e_valid = 0; e_trap = 0; e_data = '0; t_ctl = "R9"; t_data = "R9";
        end else if (!v) begin
            e_valid = 0; e_trap = 0; t_ctl = "R7"; t_data = "R7";
        end else if (op == 7'h07 && fe) begin
            e_valid = 1; e_trap = 0; e_data = model(s, imm); e_dst = d;
            t_ctl = "R4"; t_data = tag;
        end else if (op == 7'h07) begin
            e_valid = 0; e_trap = 1; e_dst = d; t_ctl = "R5"; t_data = "R5";
        end else begin
            e_valid = 0; e_trap = 1; e_dst = d; t_ctl = "R6"; t_data = "R6";
        end
    endtask

    task automatic legal(logic [8:0] imm, logic [31:0] s, string tag);
        step(0, 1, 1, 7'h07, imm, s, 4'($urandom), tag);
    endtask

    initial begin
        logic [8:0] bc [4];
        bc[0] = 9'h000; bc[1] = 9'h055; bc[2] = 9'h0AA; bc[3] = 9'h0FF;
        rst = 1; in_valid = 0; in_feat_en = 0; in_subop = '0;
        in_imm = '0; in_src = '0; in_dst = '0;
        // reset, with a legal op held to show reset priority (R9)
        step(1, 1, 1, 7'h07, 9'h0E4, 32'hDEADBEEF, 4'h3, "R9");
        step(1, 1, 1, 7'h07, 9'h0E4, 32'hDEADBEEF, 4'h3, "R9");
        // identity and reversed selectors (R1)
        legal(9'h0E4, 32'h44332211, "R1");
        legal(9'h01B, 32'h44332211, "R1");
        legal(9'h0C9, 32'hA1B2C3D4, "R1");
        // mirroring (R2)
        legal(9'h1E4, 32'h80402001, "R2");
        legal(9'h11B, 32'hF00F1234, "R2");
        // broadcast selectors, plain and mirrored (R3)
        for (int i = 0; i < 4; i++) legal(bc[i], 32'h8C4A2E01, "R3");
        for (int i = 0; i < 4; i++) legal(bc[i] | 9'h100, 32'h8C4A2E01, "R3");
        // disabled feature keeps old data (R5)
        step(0, 1, 0, 7'h07, 9'h1E4, 32'h12345678, 4'hA, "R5");
        step(0, 1, 0, 7'h07, 9'h000, 32'hFFFFFFFF, 4'h5, "R5");
        // foreign opcodes (R6)
        step(0, 1, 1, 7'h0C, 9'h0E4, 32'h0BADF00D, 4'h1, "R6");
        step(0, 1, 0, 7'h00, 9'h0E4, 32'h0BADF00D, 4'h2, "R6");
        step(0, 1, 1, 7'h7F, 9'h1FF, 32'h0BADF00D, 4'hF, "R6");
        step(0, 1, 1, 7'h06, 9'h0E4, 32'h0BADF00D, 4'h7, "R6");
        // idle gap (R7)
        step(0, 0, 1, 7'h07, 9'h0E4, 32'h11111111, 4'h0, "R7");
        step(0, 0, 1, 7'h07, 9'h0E4, 32'h11111111, 4'h0, "R7");
        // random mix, back-to-back and gapped (R1 R2 R4 R7 R8)
        for (int n = 0; n < 400; n++) begin
            int kind = $urandom_range(0, 9);
            logic [8:0] imm = 9'($urandom);
            logic [31:0] s = $urandom;
            logic [3:0] d = 4'($urandom);
            if (kind < 6)      step(0, 1, 1, 7'h07, imm, s, d, imm[8] ? "R2" : "R1");
            else if (kind == 6) step(0, 1, 0, 7'h07, imm, s, d, "R5");
            else if (kind == 7) step(0, 1, $urandom_range(0,1) == 1, 7'($urandom_range(8, 127)), imm, s, d, "R6");
            else               step(0, 0, 1, 7'h07, imm, s, d, "R7");
        end
        // mid-run reset (R9)
        legal(9'h0E4, 32'hCAFEF00D, "R1");
        step(1, 1, 1, 7'h07, 9'h0E4, 32'h55AA55AA, 4'h9, "R9");
        step(0, 0, 0, 7'h00, 9'h000, 32'h0, 4'h0, "R7");
        step(0, 0, 0, 7'h00, 9'h000, 32'h0, 4'h0, "R7");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule